// File: doc/BRIEF.md
# Vertical-Sync Clocked Serial Identity Streamer

This block sends the first 128 bytes of an external byte memory, one bit at a time, on a shared open-drain data line. The bits are paced by a slow clock derived from vertical sync (VCLK), which arrives asynchronously. It is re-timed into the system clock domain, and each rising edge of the re-timed copy advances the stream by one bit slot. After reset the line stays released for nine VCLK rising edges while the block settles. The tenth edge puts out the most significant bit of byte 00h.

Each byte fills nine slots: eight data bits, most significant first, and then a released null slot. The read pointer counts through 00h to 7Fh and wraps back to 00h, so the stream never ends. The byte is captured from the memory when its first bit goes out, so the array may change while that byte is still being sent. A mode controller has two inputs into the block. A hold input releases the line at once and freezes the sequence. A restart input sends the stream back to byte 00h without a second settling period.

Top module: `vsync_id_streamer`

## Requirements
- R1: After reset the line is released (`line_oe_o`=0, `line_bit_o`=1) and `rd_addr_o` is 00h.
- R2: During the first nine VCLK rising edges after reset, `line_oe_o` stays 0.
- R3: The tenth VCLK rising edge drives `line_oe_o`=1 with `line_bit_o` equal to bit 7 of the byte at address 00h.
- R4: Each further VCLK rising edge presents the next bit of the current byte, going from bit 7 down to bit 0.
- R5: The ninth slot of every byte is a null slot: `line_oe_o`=0 and `line_bit_o`=1.
- R6: `rd_addr_o` is 7 bits wide. After the byte at 7Fh is sent, the next byte sent is the byte at 00h.
- R7: While `hold_i`=1, `line_oe_o` is 0 in the same cycle, VCLK edges have no effect, and the stream resumes from the same bit once hold is released.
- R8: A one-cycle `restart_i` releases the line and sets `rd_addr_o` to 00h. The next VCLK rising edge drives bit 7 of byte 00h, with no new settling period.
- R9: A byte is captured when its bit 7 goes out. Later changes of `rd_data_i` do not change the remaining bits of that byte.
- R10: VCLK passes through a two-stage synchroniser. A VCLK rise that is first sampled at one system clock edge updates the line outputs at the third system clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vclk_i | input | 1 | Asynchronous bit-pacing clock derived from vertical sync |
| hold_i | input | 1 | Mode controller hold: release the line and freeze the sequence |
| restart_i | input | 1 | Mode controller restart: return the stream to byte 00h |
| rd_addr_o | output | 7 | Read address to the memory array |
| rd_data_i | input | 8 | Read data from the memory array |
| line_oe_o | output | 1 | Line drive enable (0 = released) |
| line_bit_o | output | 1 | Data bit driven onto the line when enabled |

## Verification
The hardest case to reach is the wrap from 7Fh to 00h. Getting there takes more than a thousand VCLK pulses after the settling period, so the bench runs the unchecked middle bytes in a loop and then checks the full re-sent byte 00h bit by bit. The capture rule is tested by corrupting the memory model right after a byte starts. Hold is tested by sending VCLK pulses while it is asserted. The synchroniser latency is tested by sampling between the second and third system clock edges after a VCLK rise.

// File: rtl/vsync_id_pkg.sv
package vsync_id_pkg;
  typedef enum logic {PH_WAIT = 1'b0, PH_RUN = 1'b1} stream_phase_e;
endpackage

// File: rtl/vclk_edge_sync.sv
module vclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  // R10
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/warmup_counter.sv
module warmup_counter #(
  parameter int WARM_EDGES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic start_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(WARM_EDGES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  always_comb begin
    cnt_d   = cnt_q;
    done_d  = done_q;
    start_o = 1'b0;
    cnt_en  = tick_i & ~done_q;
    if (cnt_en) begin
      if (cnt_q == CNT_W'(WARM_EDGES)) begin
        done_d  = 1'b1;
        start_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // R2
  warm_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (cnt_q == CNT_W'(WARM_EDGES)) && !done_q);
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import vsync_id_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              restart_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              drive_o,
  output logic              bit_o
);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam int SEL_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] NULL_IDX = IDX_W'(DATA_W);

  stream_phase_e     phase_q, phase_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              load, upd;
  logic [IDX_W-1:0]  msb_off;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    addr_d  = addr_q;
    byte_d  = byte_q;
    load    = 1'b0;
    upd     = restart_i | start_i | (step_i & (phase_q == PH_RUN));
    if (restart_i) begin
      addr_d = '0;
      idx_d  = NULL_IDX;
    end else if (upd) begin
      if (start_i || idx_q == NULL_IDX) begin
        load    = 1'b1;
        byte_d  = rd_data_i;
        idx_d   = '0;
        addr_d  = addr_q + 1'b1;
        phase_d = PH_RUN;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      idx_q   <= NULL_IDX;
      addr_q  <= '0;
      byte_q  <= '0;
    end else if (upd) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      addr_q  <= addr_d;
      byte_q  <= byte_d;
    end
  end

  assign msb_off   = IDX_W'(DATA_W - 1) - idx_q;
  assign drive_o   = (phase_q == PH_RUN) && (idx_q != NULL_IDX);
  assign bit_o     = drive_o ? byte_q[msb_off[SEL_W-1:0]] : 1'b1;
  assign rd_addr_o = addr_q;

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !start_i && !restart_i && phase_q == PH_RUN && idx_q != NULL_IDX)
      |=> idx_q == IDX_W'($past(idx_q) + 1'b1));
  // R6
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && addr_q == {ADDR_W{1'b1}}) |=> addr_q == '0);
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (addr_q == '0) && !drive_o);
  // R9
  byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && idx_q < NULL_IDX - 1'b1 && !restart_i) |=> $stable(byte_q));
endmodule

// File: rtl/vsync_id_streamer.sv
module vsync_id_streamer #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int WARM_EDGES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vclk_i,
  input  logic              hold_i,
  input  logic              restart_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              line_oe_o,
  output logic              line_bit_o
);
  logic vrise, tick, warm_start, warm_done, step, seq_drive, seq_bit;

  vclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(vclk_i), .rise_o(vrise)
  );

  assign tick = vrise & ~hold_i;
  assign step = tick & warm_done;

  warmup_counter #(.WARM_EDGES(WARM_EDGES)) u_warm (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .start_o(warm_start), .done_o(warm_done)
  );

  frame_sequencer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(warm_start), .step_i(step),
    .restart_i(restart_i), .rd_data_i(rd_data_i), .rd_addr_o(rd_addr_o),
    .drive_o(seq_drive), .bit_o(seq_bit)
  );

  assign line_oe_o  = seq_drive & ~hold_i;
  assign line_bit_o = line_oe_o ? seq_bit : 1'b1;

  // R2
  warm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_done |-> !line_oe_o);
  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !restart_i) |=> $stable(rd_addr_o));
endmodule

// File: tb/vsync_id_streamer_test.sv
module vsync_id_streamer_test;
  logic       clk = 1'b0;
  logic       rst_n, vclk, hold, restart, corrupt, finished;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic       oe, dbit;
  int         checks = 0;
  int         errors = 0;

  // memory model: byte(a) = a*37 + 11
  localparam logic [7:0] EXP [6] = '{8'h0B, 8'h30, 8'h55, 8'h7A, 8'h9F, 8'hC4};

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [6:0] a);
    return 8'((int'(a) * 37 + 11) & 255);
  endfunction

  assign rd_data = corrupt ? ~pat(rd_addr) : pat(rd_addr);

  vsync_id_streamer uut (
    .clk(clk), .rst_n(rst_n), .vclk_i(vclk), .hold_i(hold), .restart_i(restart),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .line_oe_o(oe), .line_bit_o(dbit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) vclk = 1'b1;
    repeat (4) @(negedge clk);
    vclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_byte(input string tag, input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      pulse();
      chk({tag, " oe"}, oe, 1'b1);
      chk({tag, " bit"}, dbit, b[k]);
    end
    pulse();
    chk("R5 null oe", oe, 1'b0);
    chk("R5 null bit", dbit, 1'b1);
  endtask

  initial begin
    finished = 1'b0;
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; vclk = 1'b0; hold = 1'b0; restart = 1'b0; corrupt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe", oe, 1'b0);
    chk("R1 bit", dbit, 1'b1);
    chk("R1 addr", rd_addr, 7'h00);

    for (int i = 0; i < 9; i++) begin
      pulse();
      chk("R2 settle oe", oe, 1'b0);
    end

    // R3 on the first entry, R4 and R5 across the table
    for (int i = 0; i < 6; i++) check_byte("R3 R4 byte", EXP[i]);

    for (int i = 6; i < 128; i++) repeat (9) pulse();
    // R6: stream returns to byte 00h after 7Fh
    pulse();
    chk("R6 wrap bit7", dbit, EXP[0][7]);
    chk("R6 addr after wrap load", rd_addr, 7'h01);
    for (int k = 6; k >= 0; k--) begin
      pulse();
      chk("R6 wrap bit", dbit, EXP[0][k]);
    end
    pulse();

    // R9: corrupt memory after byte 01h is captured
    pulse();
    chk("R9 bit7", dbit, EXP[1][7]);
    corrupt = 1'b1;
    for (int k = 6; k >= 0; k--) begin
      pulse();
      chk("R9 captured bit", dbit, EXP[1][k]);
    end
    corrupt = 1'b0;
    pulse();

    // R7: hold
    pulse();
    chk("R7 pre-hold bit", dbit, EXP[2][7]);
    @(negedge clk) hold = 1'b1;
    #1 chk("R7 oe immediate", oe, 1'b0);
    for (int i = 0; i < 3; i++) pulse();
    chk("R7 oe held", oe, 1'b0);
    chk("R7 addr frozen", rd_addr, 7'h03);
    @(negedge clk) hold = 1'b0;
    #1 chk("R7 resume oe", oe, 1'b1);
    chk("R7 resume bit", dbit, EXP[2][7]);
    pulse();
    chk("R7 next bit", dbit, EXP[2][6]);

    // R8: restart
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    chk("R8 oe", oe, 1'b0);
    chk("R8 addr", rd_addr, 7'h00);
    check_byte("R8 byte0", EXP[0]);

    // R10: latency of a VCLK rise (byte 01h bit7: oe 0 -> 1)
    @(negedge clk) vclk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 before third edge", oe, 1'b0);
    @(negedge clk);
    chk("R10 at third edge", oe, 1'b1);
    chk("R10 bit", dbit, EXP[1][7]);
    vclk = 1'b0;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule